// File: doc/BRIEF.md
# SDRAM Request Address Generator

This block sits between an application request port and a bank-level SDRAM scheduler. It takes one burst request at a time, carrying a start address, a length in application words, a wrap flag, a read/write flag and an identifier. It hands on one or two bank-level requests, each carrying a bank, row and column address and a length counted in SDRAM bus words. The application address and length are first scaled to the configured SDRAM data width. The scaled address is then decoded into column, bank and row fields, using a 2-bit setting that chooses how many column bits a page has.

A non-wrapping burst that would run past the last column of its page is cut into two sub-requests at the page boundary. A wrapping burst is passed on whole, because the column wraps further downstream. Both sides use a valid/acknowledge handshake. The application is acknowledged in the same cycle that the downstream side accepts the final sub-request. Scaled lengths are expected to be no larger than one page, so a request never needs more than two pieces. The configuration inputs are expected to stay steady while a request is in flight.

Top module: `sdr_req_split`

## Requirements
- R1: The width setting scales the address and the length by the same factor. Code 0 (32-bit bus) and code 3 pass both unchanged. Code 1 (16-bit bus) shifts both left by one. Code 2 (8-bit bus) shifts both left by two.
- R2: With column setting c (0 to 3), the page has 8+c column bits. The column is scaled address bits [7+c:0], the bank is the next two bits [9+c:8+c], and the row is the twelve bits [21+c:10+c].
- R3: The column output is 12 bits wide, with zeros above its 8+c used bits. The bank output is 2 bits and the row output is 12 bits.
- R4: A non-wrapping request whose start column plus scaled length exceeds the page size is issued as two sub-requests. The first keeps the start address, with length equal to the page size minus the start column. The second starts at column 0 of the following page, with the remaining length. The following page can carry into bank and row.
- R5: A non-wrapping request that fits inside its page is issued unchanged as a single sub-request. This includes a request that ends exactly on the last column.
- R6: A wrapping request is always issued as a single, unmodified sub-request with its wrap flag set, even when it passes the page end.
- R7: The first flag marks the first sub-request of each application request and the last flag marks the final one (both are set on a single piece). The identifier, read/write flag and wrap flag are copied onto every piece.
- R8: The application acknowledge is high only in the cycle in which the final sub-request is accepted downstream. Application inputs are not sampled again until that request has completed, so changing them mid-request has no effect.
- R9: While a sub-request is offered and not accepted, every output field holds steady.
- R10: After reset no sub-request is offered and the application acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | 2 | SDRAM bus width code (0: 32-bit, 1: 16-bit, 2: 8-bit) |
| cfg_colsel | input | 2 | Column-bit setting, page of 2^(8+c) columns |
| app_valid | input | 1 | Application request present |
| app_addr | input | APP_AW (26) | Start address in application words |
| app_len | input | LEN_W (8) | Burst length in application words |
| app_wrap | input | 1 | Burst wraps within its page |
| app_write | input | 1 | 1 for write, 0 for read |
| app_id | input | ID_W (4) | Request identifier |
| app_ack | output | 1 | Request fully handed downstream |
| bk_valid | output | 1 | Sub-request offered |
| bk_ack | input | 1 | Sub-request accepted |
| bk_bank | output | 2 | Bank address |
| bk_row | output | 12 | Row address |
| bk_col | output | 12 | Column address, zero-extended |
| bk_len | output | LEN_W+2 (10) | Length in SDRAM bus words |
| bk_write | output | 1 | Copied read/write flag |
| bk_wrap | output | 1 | Copied wrap flag |
| bk_id | output | ID_W (4) | Copied identifier |
| bk_first | output | 1 | First piece of the request |
| bk_last | output | 1 | Final piece of the request |

## Verification
The hardest case is a split whose second half carries across a bank and row boundary while the downstream side is stalling. In that case the first piece has to stay frozen, and the application inputs must not be sampled again while the second piece is still owed. The stimulus reaches it with a start address on the last column of the last bank of a row. It holds the downstream acknowledge low for several cycles and scrambles the application address and identifier after capture. The bench then checks that the second piece still lands on column 0 of the next row, and that the acknowledge appears only when that piece is accepted.

// File: rtl/sdr_req_pkg.sv
package sdr_req_pkg;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 12;
  localparam int MIN_CB = 8;
  localparam int NSEL   = 4;

  // left shift applied to address and length for a width code
  function automatic int unsigned scale_shift(input logic [1:0] wsel);
    case (wsel)
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 0;
    endcase
  endfunction

  // number of column bits in a page for a column setting
  function automatic int unsigned col_bits(input logic [1:0] csel);
    return MIN_CB + int'(csel);
  endfunction
endpackage

// File: rtl/sdr_req_scale.sv
module sdr_req_scale
  import sdr_req_pkg::*;
#(
  parameter int AW = 26,
  parameter int LW = 8
) (
  input  logic [AW-1:0] app_addr,
  input  logic [LW-1:0] app_len,
  input  logic [1:0]    width_sel,
  output logic [AW+1:0] int_addr,
  output logic [LW+1:0] int_len
);
  logic [AW+1:0] addr_ext;
  logic [LW+1:0] len_ext;

  assign addr_ext = {2'b00, app_addr};
  assign len_ext  = {2'b00, app_len};
  assign int_addr = addr_ext << scale_shift(width_sel);
  assign int_len  = len_ext << scale_shift(width_sel);
endmodule

// File: rtl/sdr_page_split.sv
module sdr_page_split
  import sdr_req_pkg::*;
#(
  parameter int IAW = 28,
  parameter int ILW = 10
) (
  input  logic [IAW-1:0] base_addr,
  input  logic [ILW-1:0] base_len,
  input  logic           wrap,
  input  logic [1:0]     col_sel,
  output logic           crosses,
  output logic [ILW-1:0] len_a,
  output logic [IAW-1:0] addr_b,
  output logic [ILW-1:0] len_b
);
  logic [IAW-1:0] page_sz;
  logic [IAW-1:0] col_off;
  logic [IAW-1:0] room;
  logic [IAW-1:0] len_wide;

  assign page_sz  = IAW'(1) << col_bits(col_sel);
  assign col_off  = base_addr & (page_sz - IAW'(1));
  assign room     = page_sz - col_off;
  assign len_wide = IAW'(base_len);
  assign crosses  = !wrap && (len_wide > room);
  assign len_a    = crosses ? ILW'(room) : base_len;
  assign addr_b   = base_addr + room;
  assign len_b    = base_len - ILW'(room);
endmodule

// File: rtl/sdr_addr_decode.sv
module sdr_addr_decode
  import sdr_req_pkg::*;
#(
  parameter int IAW = 28
) (
  input  logic [IAW-1:0]    addr,
  input  logic [1:0]        col_sel,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  logic [BANK_W-1:0] bank_c [NSEL];
  logic [ROW_W-1:0]  row_c  [NSEL];
  logic [COL_W-1:0]  col_c  [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    localparam int CB = MIN_CB + g;
    assign col_c[g]  = COL_W'(addr[CB-1:0]);
    assign bank_c[g] = addr[CB+BANK_W-1:CB];
    assign row_c[g]  = addr[CB+BANK_W+ROW_W-1:CB+BANK_W];
  end

  assign bank = bank_c[col_sel];
  assign row  = row_c[col_sel];
  assign col  = col_c[col_sel];
endmodule

// File: rtl/sdr_req_split.sv
module sdr_req_split
  import sdr_req_pkg::*;
#(
  parameter int APP_AW = 26,
  parameter int LEN_W  = 8,
  parameter int ID_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_width,
  input  logic [1:0]          cfg_colsel,
  input  logic                app_valid,
  input  logic [APP_AW-1:0]   app_addr,
  input  logic [LEN_W-1:0]    app_len,
  input  logic                app_wrap,
  input  logic                app_write,
  input  logic [ID_W-1:0]     app_id,
  output logic                app_ack,
  output logic                bk_valid,
  input  logic                bk_ack,
  output logic [1:0]          bk_bank,
  output logic [11:0]         bk_row,
  output logic [11:0]         bk_col,
  output logic [LEN_W+1:0]    bk_len,
  output logic                bk_write,
  output logic                bk_wrap,
  output logic [ID_W-1:0]     bk_id,
  output logic                bk_first,
  output logic                bk_last
);
  localparam int IAW = APP_AW + 2;
  localparam int ILW = LEN_W + 2;

  // scaled request and split results
  logic [IAW-1:0] s_addr;
  logic [ILW-1:0] s_len;
  logic           s_cross;
  logic [ILW-1:0] s_len_a;
  logic [IAW-1:0] s_addr_b;
  logic [ILW-1:0] s_len_b;

  // held state
  logic [IAW-1:0] cur_addr, nxt_addr;
  logic [ILW-1:0] cur_len, nxt_len;
  logic           pend_b;

  // named events
  logic take_req;
  logic hand_off;
  logic advance;

  sdr_req_scale #(.AW(APP_AW), .LW(LEN_W)) u_scale (
    .app_addr (app_addr),
    .app_len  (app_len),
    .width_sel(cfg_width),
    .int_addr (s_addr),
    .int_len  (s_len)
  );

  sdr_page_split #(.IAW(IAW), .ILW(ILW)) u_split (
    .base_addr(s_addr),
    .base_len (s_len),
    .wrap     (app_wrap),
    .col_sel  (cfg_colsel),
    .crosses  (s_cross),
    .len_a    (s_len_a),
    .addr_b   (s_addr_b),
    .len_b    (s_len_b)
  );

  sdr_addr_decode #(.IAW(IAW)) u_dec (
    .addr   (cur_addr),
    .col_sel(cfg_colsel),
    .bank   (bk_bank),
    .row    (bk_row),
    .col    (bk_col)
  );

  assign take_req = app_valid && !bk_valid;
  assign hand_off = bk_valid && bk_ack;
  assign advance  = hand_off && pend_b;
  assign app_ack  = hand_off && !pend_b;
  assign bk_last  = !pend_b;
  assign bk_len   = cur_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_valid <= 1'b0;
      pend_b   <= 1'b0;
      bk_first <= 1'b0;
      cur_addr <= '0;
      cur_len  <= '0;
      nxt_addr <= '0;
      nxt_len  <= '0;
      bk_write <= 1'b0;
      bk_wrap  <= 1'b0;
      bk_id    <= '0;
    end else if (take_req) begin
      bk_valid <= 1'b1;
      bk_first <= 1'b1;
      pend_b   <= s_cross;
      cur_addr <= s_addr;
      cur_len  <= s_len_a;
      nxt_addr <= s_addr_b;
      nxt_len  <= s_len_b;
      bk_write <= app_write;
      bk_wrap  <= app_wrap;
      bk_id    <= app_id;
    end else if (advance) begin
      bk_first <= 1'b0;
      pend_b   <= 1'b0;
      cur_addr <= nxt_addr;
      cur_len  <= nxt_len;
    end else if (hand_off) begin
      bk_valid <= 1'b0;
    end
  end

  // checks
  logic [IAW-1:0] page_now;
  assign page_now = IAW'(1) << col_bits(cfg_colsel);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bk_valid && !bk_ack |=> bk_valid && $stable(bk_col) && $stable(bk_row)
      && $stable(bk_bank) && $stable(bk_len) && $stable(bk_id) && $stable(bk_last));

  // R4
  second_piece_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bk_valid && bk_ack && !bk_last |=> bk_valid && !bk_first && bk_last && (bk_col == '0));

  // R6
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bk_valid && bk_wrap |-> bk_first && bk_last);

  // R5
  page_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bk_valid && !bk_wrap |-> (IAW'(bk_col) + IAW'(bk_len)) <= page_now);

  // R3
  col_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bk_valid |-> (IAW'(bk_col) >> col_bits(cfg_colsel)) == '0);

  // R8
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_ack |=> !bk_valid);
endmodule

// File: tb/sdr_req_split_tb.sv
module sdr_req_split_tb;
  localparam int APP_AW = 26;
  localparam int LEN_W  = 8;
  localparam int ID_W   = 4;
  localparam int ILW    = LEN_W + 2;

  typedef struct packed {
    logic [1:0]        w;
    logic [1:0]        cs;
    logic [APP_AW-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              wrap;
    logic              split;
    logic [1:0]        b0;
    logic [11:0]       r0;
    logic [11:0]       c0;
    logic [ILW-1:0]    l0;
    logic [1:0]        b1;
    logic [11:0]       r1;
    logic [11:0]       c1;
    logic [ILW-1:0]    l1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 26'h123,   8'd4, 1'b0, 1'b0, 2'd1, 12'h000, 12'h023, 10'd4,  2'd0, 12'h000, 12'h000, 10'd0},
    '{2'd1, 2'd0, 26'h07E,   8'd4, 1'b0, 1'b1, 2'd0, 12'h000, 12'h0FC, 10'd4,  2'd1, 12'h000, 12'h000, 10'd4},
    '{2'd2, 2'd1, 26'h10000, 8'd3, 1'b0, 1'b0, 2'd0, 12'h080, 12'h000, 10'd12, 2'd0, 12'h000, 12'h000, 10'd0},
    '{2'd0, 2'd3, 26'h1FFE,  8'd5, 1'b0, 1'b1, 2'd3, 12'h000, 12'h7FE, 10'd2,  2'd0, 12'h001, 12'h000, 10'd3},
    '{2'd0, 2'd3, 26'h1FFE,  8'd5, 1'b1, 1'b0, 2'd3, 12'h000, 12'h7FE, 10'd5,  2'd0, 12'h000, 12'h000, 10'd0},
    '{2'd0, 2'd2, 26'h3FC,   8'd4, 1'b0, 1'b0, 2'd0, 12'h000, 12'h3FC, 10'd4,  2'd0, 12'h000, 12'h000, 10'd0},
    '{2'd1, 2'd2, 26'h1FF,   8'd2, 1'b0, 1'b1, 2'd0, 12'h000, 12'h3FE, 10'd2,  2'd1, 12'h000, 12'h000, 10'd2},
    '{2'd0, 2'd0, 26'h3FFFF, 8'd2, 1'b0, 1'b1, 2'd3, 12'h0FF, 12'h0FF, 10'd1,  2'd0, 12'h100, 12'h000, 10'd1},
    '{2'd3, 2'd0, 26'hABC,   8'd1, 1'b0, 1'b0, 2'd2, 12'h002, 12'h0BC, 10'd1,  2'd0, 12'h000, 12'h000, 10'd0}
  };
  localparam string VTAG [NV] = '{"R1 R2", "R1 R4", "R1 R2", "R2 R4", "R6", "R5",
                                  "R1 R4", "R4 R2", "R1 R3"};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cfg_width = '0;
  logic [1:0]        cfg_colsel = '0;
  logic              app_valid = 1'b0;
  logic [APP_AW-1:0] app_addr = '0;
  logic [LEN_W-1:0]  app_len = '0;
  logic              app_wrap = 1'b0;
  logic              app_write = 1'b0;
  logic [ID_W-1:0]   app_id = '0;
  logic              app_ack;
  logic              bk_valid;
  logic              bk_ack = 1'b0;
  logic [1:0]        bk_bank;
  logic [11:0]       bk_row;
  logic [11:0]       bk_col;
  logic [ILW-1:0]    bk_len;
  logic              bk_write;
  logic              bk_wrap;
  logic [ID_W-1:0]   bk_id;
  logic              bk_first;
  logic              bk_last;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  always #10 clk = ~clk;

  sdr_req_split #(.APP_AW(APP_AW), .LEN_W(LEN_W), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_colsel(cfg_colsel),
    .app_valid(app_valid), .app_addr(app_addr), .app_len(app_len),
    .app_wrap(app_wrap), .app_write(app_write), .app_id(app_id), .app_ack(app_ack),
    .bk_valid(bk_valid), .bk_ack(bk_ack), .bk_bank(bk_bank), .bk_row(bk_row),
    .bk_col(bk_col), .bk_len(bk_len), .bk_write(bk_write), .bk_wrap(bk_wrap),
    .bk_id(bk_id), .bk_first(bk_first), .bk_last(bk_last)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // packs one offered piece for comparison
  function automatic logic [63:0] piece_now();
    return {bk_bank, bk_row, bk_col, bk_len, bk_first, bk_last, bk_write, bk_wrap, bk_id};
  endfunction

  function automatic logic [63:0] piece_exp(input logic [1:0] b, input logic [11:0] r,
      input logic [11:0] c, input logic [ILW-1:0] l, input logic f, input logic la,
      input logic wr, input logic wp, input logic [ID_W-1:0] id);
    return {b, r, c, l, f, la, wr, wp, id};
  endfunction

  task automatic do_req(input vec_t v, input string tag, input logic [ID_W-1:0] id,
                        input int stall, input bit scramble);
    int pieces = 0;
    int waits = 0;
    int guard = 0;
    bit done = 0;
    logic [63:0] held = '0;
    logic [63:0] exp;
    @(negedge clk);
    cfg_width = v.w; cfg_colsel = v.cs;
    app_addr = v.addr; app_len = v.len; app_wrap = v.wrap;
    app_write = id[0]; app_id = id; app_valid = 1'b1;
    while (!done && guard < 50) begin
      guard++;
      @(negedge clk);
      bk_ack = 1'b0;
      if (scramble) begin
        app_addr = ~v.addr; app_id = ~id; app_len = 8'd1;
      end
      if (bk_valid) begin
        if (waits == 0) held = piece_now();
        if (waits < stall) begin
          waits++;
          #1;
          chk(app_ack == 1'b0, "R8", "ack during stall", app_ack, 0);
          chk(piece_now() == held, "R9", "held fields", piece_now(), held);
        end else begin
          waits = 0;
          bk_ack = 1'b1;
          #1;
          if (pieces == 0)
            exp = piece_exp(v.b0, v.r0, v.c0, v.l0, 1'b1, !v.split, id[0], v.wrap, id);
          else
            exp = piece_exp(v.b1, v.r1, v.c1, v.l1, 1'b0, 1'b1, id[0], v.wrap, id);
          chk(piece_now() == exp, {tag, " R7"}, $sformatf("piece %0d", pieces),
              piece_now(), exp);
          chk(app_ack == bk_last, "R8", "ack only on final piece", app_ack, bk_last);
          if (app_ack) done = 1;
          pieces++;
        end
      end
    end
    @(posedge clk);
    #1;
    app_valid = 1'b0; bk_ack = 1'b0;
    chk(pieces == (v.split ? 2 : 1), tag, "piece count", pieces, v.split ? 2 : 1);
    @(negedge clk);
    chk(bk_valid == 1'b0, "R8", "idle after ack", bk_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(bk_valid == 1'b0, "R10", "bk_valid in reset", bk_valid, 0);
    chk(app_ack == 1'b0, "R10", "app_ack in reset", app_ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bk_valid == 1'b0, "R10", "bk_valid after reset", bk_valid, 0);

    for (int i = 0; i < NV; i++)
      do_req(VECS[i], VTAG[i], ID_W'(i + 3), 0, 1'b0);

    // split across bank and row with downstream stalls and changed inputs (R8, R9, R4)
    do_req(VECS[7], "R4 R8", 4'hA, 3, 1'b1);
    // wrapping request through a stall (R6, R9)
    do_req(VECS[4], "R6 R9", 4'h5, 2, 1'b0);

    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule